// File: doc/BRIEF.md
# SPI Slave Transaction Engine

This block is the serial side of an SPI peripheral working as a bus slave. Before a transaction, local logic loads the characters to return into a transmit queue. The block then waits for the external master to select it. While the chip-select input is active, each character the master clocks in lands in a receive queue. Each character clocked out comes from the transmit queue. When that queue is empty, a programmable filler byte is sent instead, so the block never stalls the master. The transaction lasts exactly as long as the master holds chip select, and releasing it ends the transaction.

The serial clock, chip select and serial data input are sampled into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. The clock mode and the character length are set through plain configuration pins. Both queues use a valid/ready stream interface. A word moves only in a cycle where valid and ready are both high. Ready on the transmit side falls when that queue is full. On the receive side, valid and data hold steady until the consumer raises ready. The serial side cannot be back-pressured, so a character that arrives while the receive queue is full is dropped and reported.

Top module: `spi_slave_engine`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_valid`=0, `miso_oe`=0, `xfer_done`=0, `tx_underrun`=0, `rx_overflow`=0, `tx_thresh_hit`=1 and `rx_thresh_hit`=0.
- R2: `cfg_mode` bit 0 is the idle clock level and bit 1 is the phase. Codes 0..3 give (phase, polarity) = (0,0), (0,1), (1,0), (1,1). With phase 0, data is sampled on the edge leaving the idle level. With phase 1, data is sampled on the edge returning to it. Characters go most-significant bit first, in both directions.
- R3: Transmit characters leave the queue in the order they were written, one per character clocked by the master. A character is taken from the queue only when the master clocks its first bit.
- R4: When the transmit queue is empty at the start of a character, `cfg_dummy` is sent instead. `tx_underrun` is then set and stays set until the next chip-select assertion.
- R5: A character has `cfg_bits_m1`+1 bits, from 1 to 8. Each completed character is written into the receive queue right-aligned, with its upper bits zero.
- R6: A character that is incomplete when chip select is released is discarded.
- R7: `xfer_done` pulses high for exactly one cycle after each chip-select release.
- R8: A completed character that arrives while the receive queue is full is dropped and `rx_overflow` is set. The flag stays set until the next chip-select assertion. Queued data is unaffected.
- R9: `miso_oe` is high only while the synchronized chip select is active. The pad must leave `miso` high-impedance otherwise.
- R10: `tx_thresh_hit` is high while the transmit fill level is at or below `cfg_tx_thresh`. `rx_thresh_hit` is high while the receive fill level is above `cfg_rx_thresh`. Both thresholds range from 0 to 8.
- R11: Both queues are 8 deep. `tx_ready` is low only when the transmit queue is full. `rx_valid` is high when the receive queue holds data, and `rx_data` holds steady until it is accepted.
- R12: Serial clock transitions while chip select is inactive have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Clock mode code (bit 0 idle level, bit 1 phase) |
| cfg_bits_m1 | input | 3 | Character length minus one |
| cfg_dummy | input | 8 | Filler character sent when the transmit queue is empty |
| cfg_tx_thresh | input | 4 | Transmit fill-level threshold |
| cfg_rx_thresh | input | 4 | Receive fill-level threshold |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 8 | Transmit character, right-aligned |
| tx_ready | output | 1 | Transmit queue can accept |
| rx_valid | output | 1 | Received character available |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | input | 1 | Consumer accepts the received character |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low chip select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the serial data pad |
| xfer_done | output | 1 | One-cycle pulse at the end of a transaction |
| tx_thresh_hit | output | 1 | Transmit level at or below threshold |
| rx_thresh_hit | output | 1 | Receive level above threshold |
| tx_underrun | output | 1 | Filler character was sent during this transaction |
| rx_overflow | output | 1 | A received character was dropped during this transaction |

## Verification
The assertions assume a well-behaved master. Chip select is released no sooner than a few system cycles after the last serial clock edge. Every serial clock level lasts at least two system cycles longer than the synchronizer latency. The configuration pins change only while chip select is inactive. The bench keeps each serial clock half-period at six system cycles. It changes the mode and the character length only between transactions, with settle time allowed. It asserts the receive ready only while the receive queue reports valid data. Spurious serial clock toggles are driven only while chip select is inactive.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // code bit 0 is the idle clock level, bit 1 the phase
  function automatic spi_mode_t decode_mode(input logic [1:0] code);
    spi_mode_t m;
    m.cpol = code[0];
    m.cpha = code[1];
    return m;
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_fifo.sv
module spi_slv_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign level     = cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_head_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
  import spi_slv_pkg::*;
#(
  parameter int W  = 8,
  localparam int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          ss_n_s,
  input  logic          mosi_s,
  input  logic [1:0]    cfg_mode,
  input  logic [BW-1:0] cfg_bits_m1,
  input  logic [W-1:0]  cfg_dummy,
  input  logic          txq_valid,
  input  logic [W-1:0]  txq_data,
  output logic          txq_pop,
  output logic          rxq_push,
  output logic [W-1:0]  rxq_data,
  input  logic          rxq_ready,
  output logic          miso,
  output logic          miso_oe,
  output logic          done,
  output logic          underrun,
  output logic          overflow
);

  spi_mode_t     md;
  logic          sclk_q, ss_q;
  logic          ss_act, start, stop, moved, lead, trail, smp, shf, take;
  logic [W-1:0]  tx_sh, rx_sh, fetched, rx_next;
  logic [BW-1:0] tx_pos, rx_pos;
  logic          pending;

  assign md = decode_mode(cfg_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_n_s;
    end
  end

  assign ss_act  = ~ss_n_s;
  assign start   = ss_q & ~ss_n_s;
  assign stop    = ~ss_q & ss_n_s;
  assign moved   = ss_act & (sclk_s != sclk_q);
  assign lead    = moved & (sclk_s != md.cpol);
  assign trail   = moved & (sclk_s == md.cpol);
  assign smp     = md.cpha ? trail : lead;
  assign shf     = md.cpha ? lead : trail;

  // a character is committed when its first bit is clocked
  assign fetched = txq_valid ? txq_data : cfg_dummy;
  assign take    = pending & (md.cpha ? shf : smp);
  assign txq_pop = take & txq_valid;
  assign miso    = (pending & ~md.cpha) ? fetched[cfg_bits_m1] : tx_sh[cfg_bits_m1];
  assign miso_oe = ss_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      tx_pos   <= '0;
      pending  <= 1'b0;
      underrun <= 1'b0;
    end else if (start) begin
      tx_pos   <= '0;
      pending  <= 1'b1;
      underrun <= 1'b0;
    end else begin
      if (take) underrun <= underrun | ~txq_valid;
      if (md.cpha) begin
        if (shf) begin
          tx_sh <= pending ? fetched : (tx_sh << 1);
          if (tx_pos == cfg_bits_m1) begin
            tx_pos  <= '0;
            pending <= 1'b1;
          end else begin
            tx_pos  <= tx_pos + 1'b1;
            pending <= 1'b0;
          end
        end
      end else begin
        if (smp && pending) begin
          tx_sh   <= fetched;
          pending <= 1'b0;
        end
        if (shf) begin
          if (tx_pos == cfg_bits_m1) begin
            tx_pos  <= '0;
            pending <= 1'b1;
          end else begin
            tx_sh  <= tx_sh << 1;
            tx_pos <= tx_pos + 1'b1;
          end
        end
      end
    end
  end

  assign rx_next = {rx_sh[W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_pos   <= '0;
      rxq_push <= 1'b0;
      rxq_data <= '0;
      overflow <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= stop;
      rxq_push <= 1'b0;
      if (start) begin
        rx_sh    <= '0;
        rx_pos   <= '0;
        overflow <= 1'b0;
      end else begin
        if (rxq_push && !rxq_ready) overflow <= 1'b1;
        if (smp) begin
          if (rx_pos == cfg_bits_m1) begin
            rxq_push <= 1'b1;
            rxq_data <= rx_next;
            rx_sh    <= '0;
            rx_pos   <= '0;
          end else begin
            rx_sh  <= rx_next;
            rx_pos <= rx_pos + 1'b1;
          end
        end
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !miso_oe);

  assert_push_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_push |-> miso_oe);

  assert_underrun_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(miso_oe));

endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine #(
  parameter int  W     = 8,
  parameter int  DEPTH = 8,
  localparam int BW    = $clog2(W),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_mode,
  input  logic [BW-1:0] cfg_bits_m1,
  input  logic [W-1:0]  cfg_dummy,
  input  logic [CW-1:0] cfg_tx_thresh,
  input  logic [CW-1:0] cfg_rx_thresh,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [W-1:0]  rx_data,
  input  logic          rx_ready,
  input  logic          sclk,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          xfer_done,
  output logic          tx_thresh_hit,
  output logic          rx_thresh_hit,
  output logic          tx_underrun,
  output logic          rx_overflow
);

  logic [2:0]    pins_s;
  logic          txq_valid, txq_pop, rxq_push, rxq_ready;
  logic [W-1:0]  txq_data, rxq_data;
  logic [CW-1:0] tx_lvl, rx_lvl;

  spi_slv_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, ss_n, mosi}), .q(pins_s)
  );

  spi_slv_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .out_valid(txq_valid), .out_data(txq_data), .out_ready(txq_pop),
    .level(tx_lvl)
  );

  spi_slv_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rxq_push), .in_data(rxq_data), .in_ready(rxq_ready),
    .out_valid(rx_valid), .out_data(rx_data), .out_ready(rx_ready),
    .level(rx_lvl)
  );

  spi_slv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .ss_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .cfg_mode(cfg_mode), .cfg_bits_m1(cfg_bits_m1), .cfg_dummy(cfg_dummy),
    .txq_valid(txq_valid), .txq_data(txq_data), .txq_pop(txq_pop),
    .rxq_push(rxq_push), .rxq_data(rxq_data), .rxq_ready(rxq_ready),
    .miso(miso), .miso_oe(miso_oe), .done(xfer_done),
    .underrun(tx_underrun), .overflow(rx_overflow)
  );

  assign tx_thresh_hit = (tx_lvl <= cfg_tx_thresh);
  assign rx_thresh_hit = (rx_lvl > cfg_rx_thresh);

  assert_ovf_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overflow) |-> ($past(rx_lvl) == CW'(DEPTH)));

  assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun) |-> ($past(tx_lvl) == '0));

endmodule

// File: tb/tb_spi_slave_engine.sv
module tb_spi_slave_engine;

  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [2:0] cfg_bits_m1 = 3'd7;
  logic [7:0] cfg_dummy = 8'h00;
  logic [3:0] cfg_tx_thresh = 4'd0;
  logic [3:0] cfg_rx_thresh = 4'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, rx_ready;
  logic [7:0] rx_data;
  logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, xfer_done, tx_thresh_hit, rx_thresh_hit;
  logic       tx_underrun, rx_overflow;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;

  // mode, bits-1, preloaded tx, mosi char, expected miso char, expected rx char
  localparam logic [36:0] VECS [8] = '{
    {2'd0, 3'd7, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
    {2'd1, 3'd7, 8'h5A, 8'hC3, 8'h5A, 8'hC3},
    {2'd2, 3'd7, 8'h81, 8'h7E, 8'h81, 8'h7E},
    {2'd3, 3'd7, 8'hF0, 8'h0F, 8'hF0, 8'h0F},
    {2'd0, 3'd3, 8'h0B, 8'h06, 8'h0B, 8'h06},
    {2'd3, 3'd4, 8'h1D, 8'h15, 8'h1D, 8'h15},
    {2'd1, 3'd0, 8'h01, 8'h01, 8'h01, 8'h01},
    {2'd2, 3'd6, 8'h55, 8'h2A, 8'h55, 8'h2A}
  };

  assign rx_ready = rx_pop_req;
  logic rx_pop_req = 1'b0;

  spi_slave_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bits_m1(cfg_bits_m1),
    .cfg_dummy(cfg_dummy), .cfg_tx_thresh(cfg_tx_thresh), .cfg_rx_thresh(cfg_rx_thresh),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .xfer_done(xfer_done), .tx_thresh_hit(tx_thresh_hit), .rx_thresh_hit(rx_thresh_hit),
    .tx_underrun(tx_underrun), .rx_overflow(rx_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (xfer_done) done_cnt++;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [2:0] bm1);
    @(negedge clk);
    cfg_mode = m;
    cfg_bits_m1 = bm1;
    sclk = m[0];
    wait_n(8);
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] v, output logic ok);
    @(negedge clk);
    ok = rx_valid;
    v = rx_data;
    if (ok) rx_pop_req = 1'b1;
    @(negedge clk);
    rx_pop_req = 1'b0;
  endtask

  task automatic ss_begin();
    @(negedge clk);
    ss_n = 1'b0;
    wait_n(H);
  endtask

  task automatic ss_end();
    wait_n(H);
    ss_n = 1'b1;
    wait_n(8);
  endtask

  task automatic xchar(input int nbits, input logic [7:0] mo, output logic [7:0] got);
    logic cpol, cpha;
    cpol = cfg_mode[0];
    cpha = cfg_mode[1];
    got = 8'h00;
    for (int i = nbits - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = mo[i];
        wait_n(H);
        got[i] = miso;
        sclk = ~cpol;
        wait_n(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        mosi = mo[i];
        wait_n(H);
        got[i] = miso;
        sclk = cpol;
        wait_n(H);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got, v;
    logic ok;
    int dprev;

    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(miso_oe == 1'b0, "R1 miso_oe", miso_oe, 0);
    chk(xfer_done == 1'b0, "R1 xfer_done", xfer_done, 0);
    chk(tx_underrun == 1'b0 && rx_overflow == 1'b0, "R1 flags", {tx_underrun, rx_overflow}, 0);
    chk(tx_thresh_hit == 1'b1 && rx_thresh_hit == 1'b0, "R1 thresholds",
        {tx_thresh_hit, rx_thresh_hit}, 2);

    // table of single-character transactions: R2 R3 R5 R7 R9
    for (int k = 0; k < 8; k++) begin
      logic [36:0] vec;
      vec = VECS[k];
      set_mode(vec[36:35], vec[34:32]);
      push_tx(vec[31:24]);
      dprev = done_cnt;
      ss_begin();
      chk(miso_oe == 1'b1, "R9 oe active", miso_oe, 1);
      xchar(int'(vec[34:32]) + 1, vec[23:16], got);
      ss_end();
      chk(got == vec[15:8], "R2 miso char", got, vec[15:8]);
      chk(miso_oe == 1'b0, "R9 oe idle", miso_oe, 0);
      chk(done_cnt == dprev + 1, "R7 done pulse", done_cnt - dprev, 1);
      pop_rx(v, ok);
      chk(ok && v == vec[7:0], "R5 rx char", v, vec[7:0]);
    end

    // R12 clock toggles with chip select inactive
    set_mode(2'd0, 3'd7);
    push_tx(8'h6B);
    for (int t = 0; t < 5; t++) begin
      sclk = 1'b1; mosi = 1'b1; wait_n(H);
      sclk = 1'b0; wait_n(H);
    end
    chk(rx_valid == 1'b0, "R12 no rx while idle", rx_valid, 0);
    ss_begin();
    xchar(8, 8'h92, got);
    ss_end();
    chk(got == 8'h6B, "R12 tx unaffected", got, 8'h6B);
    pop_rx(v, ok);
    chk(ok && v == 8'h92, "R12 rx clean", v, 8'h92);

    // R4 dummy byte and sticky underrun
    cfg_dummy = 8'hC6;
    push_tx(8'h9A);
    ss_begin();
    xchar(8, 8'h01, got);
    chk(got == 8'h9A, "R4 first real", got, 8'h9A);
    xchar(8, 8'h02, got);
    chk(got == 8'hC6, "R4 dummy", got, 8'hC6);
    xchar(8, 8'h03, got);
    chk(got == 8'hC6, "R4 dummy again", got, 8'hC6);
    ss_end();
    chk(tx_underrun == 1'b1, "R4 underrun sticky", tx_underrun, 1);
    for (int j = 1; j <= 3; j++) begin
      pop_rx(v, ok);
      chk(ok && v == 8'(j), "R5 rx during underrun", v, j);
    end
    push_tx(8'h77);
    ss_begin();
    chk(tx_underrun == 1'b0, "R4 cleared at select", tx_underrun, 0);
    xchar(8, 8'h04, got);
    ss_end();
    chk(tx_underrun == 1'b0 && got == 8'h77, "R4 no underrun", got, 8'h77);
    pop_rx(v, ok);

    // R6 partial character discarded
    set_mode(2'd3, 3'd7);
    push_tx(8'h11);
    push_tx(8'h22);
    ss_begin();
    xchar(8, 8'h44, got);
    chk(got == 8'h11, "R3 first of two", got, 8'h11);
    xchar(3, 8'h07, got);
    ss_end();
    pop_rx(v, ok);
    chk(ok && v == 8'h44, "R6 full char kept", v, 8'h44);
    pop_rx(v, ok);
    chk(ok == 1'b0, "R6 partial dropped", ok, 0);

    // R10 R11 thresholds, full queue and ordering
    set_mode(2'd0, 3'd7);
    cfg_tx_thresh = 4'd2;
    cfg_rx_thresh = 4'd1;
    wait_n(2);
    chk(tx_thresh_hit == 1'b1, "R10 tx empty hit", tx_thresh_hit, 1);
    for (int j = 0; j < 8; j++) push_tx(8'h30 + 8'(j));
    wait_n(1);
    chk(tx_ready == 1'b0, "R11 tx full", tx_ready, 0);
    chk(tx_thresh_hit == 1'b0, "R10 tx above", tx_thresh_hit, 0);
    ss_begin();
    for (int j = 0; j < 8; j++) begin
      xchar(8, 8'hE0 + 8'(j), got);
      chk(got == 8'h30 + 8'(j), "R3 queue order", got, 8'h30 + j);
    end
    ss_end();
    chk(tx_thresh_hit == 1'b1 && tx_ready == 1'b1, "R10 tx drained",
        {tx_thresh_hit, tx_ready}, 3);
    chk(rx_thresh_hit == 1'b1, "R10 rx above", rx_thresh_hit, 1);
    v = rx_data;
    wait_n(3);
    chk(rx_valid && rx_data == v, "R11 rx hold", rx_data, v);
    for (int j = 0; j < 7; j++) begin
      pop_rx(v, ok);
      chk(ok && v == 8'hE0 + 8'(j), "R5 rx order", v, 8'hE0 + j);
    end
    chk(rx_thresh_hit == 1'b0, "R10 rx at level", rx_thresh_hit, 0);
    pop_rx(v, ok);

    // R8 receive overflow
    ss_begin();
    for (int j = 0; j < 9; j++) xchar(8, 8'h10 + 8'(j), got);
    ss_end();
    chk(rx_overflow == 1'b1, "R8 overflow flag", rx_overflow, 1);
    for (int j = 0; j < 8; j++) begin
      pop_rx(v, ok);
      chk(ok && v == 8'h10 + 8'(j), "R8 kept data", v, 8'h10 + j);
    end
    pop_rx(v, ok);
    chk(ok == 1'b0, "R8 ninth dropped", ok, 0);
    push_tx(8'h01);
    ss_begin();
    chk(rx_overflow == 1'b0, "R8 cleared at select", rx_overflow, 0);
    ss_end();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule